// File: doc/BRIEF.md
# External Interrupt Request Latch

This block turns asynchronous external interrupt sources into one pending request for a small 8-bit CPU core. The main source is an active-low interrupt line, which may be shared by several open-drain devices wired together. A group of port inputs with the opposite, active-high polarity can be merged into the same request. Each input goes through a synchronizer. The inputs are then folded into one polarity-normalized "active" signal, and a small state machine detects events on that signal and holds them in a pending latch.

Two static options are fixed while reset is asserted. The first picks the trigger mode: edge-only, or edge-plus-level. The second decides whether the port group may be routed into the request at all. A run-time group enable bit, written by software through a write strobe, then switches all port inputs in or out together. The CPU sees the pending flag directly and a masked request line. It clears the latch with a one-cycle acknowledge pulse.

The state machine has three named states:
- **ST_WARM** covers the cycles after reset while the synchronizers fill. Nothing is latched in this state.
- **ST_IDLE** means no request is held.
- **ST_PEND** means a request is latched.

It moves between them on three transitions:
- **ST_WARM to ST_IDLE**, when the warm-up count reaches the synchronizer depth.
- **ST_IDLE to ST_PEND**, on an edge, or on an active level in level mode.
- **ST_PEND to ST_IDLE**, on an acknowledge with no simultaneous new edge.

Top module: `ext_irq_latch`

## Requirements
- R1: While reset is asserted, `pending`, `irq_req` and `grp_en` are all 0.
- R2: After reset is released, the latch stays in warm-up for SYNC_STAGES+1 cycles. An input that was already active through reset is not taken as an edge.
- R3: In edge-only mode (`opt_level`=0), a falling edge on `irq_n` sets `pending`. `pending` goes high after the second rising clock edge following the first clock edge that samples the new pin value. In total, `pending` is high at the third clock edge that samples the changed pin.
- R4: In edge-only mode, once a request has been acknowledged, a pin that stays low latches nothing more. A new request needs the pin to return high and then fall again.
- R5: In level mode (`opt_level`=1), an active level on any enabled source sets `pending`. If a source is still active when an acknowledge arrives, `pending` reads 0 for exactly one cycle and then sets again.
- R6: `ack`=1 clears `pending` in the next cycle. An acknowledge while nothing is pending has no effect. If an acknowledge coincides with a new edge, `pending` stays set.
- R7: The port inputs are active-high: a rising edge, or a high level in level mode, counts as activity. They take part only when `opt_port`=1 and `grp_en`=1. `grp_en` loads `grp_wdata` on a cycle with `grp_wr`=1 and otherwise holds its value.
- R8: Edges are detected on the merged active signal. A source that becomes active while another source already holds the merged signal active gives no new edge.
- R9: `irq_req` equals `pending` AND `irq_en`. `pending` stays readable while `irq_en`=0.
- R10: Once set, `pending` holds until an acknowledge clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_level | input | 1 | Static trigger option: 0 edge-only, 1 edge plus level |
| opt_port | input | 1 | Static option allowing the port group to feed the request |
| irq_n | input | 1 | Asynchronous active-low interrupt pin |
| port_in | input | PORT_W | Asynchronous active-high port interrupt inputs |
| grp_wr | input | 1 | Write strobe for the group enable bit |
| grp_wdata | input | 1 | Value written into the group enable bit |
| ack | input | 1 | One-cycle acknowledge from the CPU |
| irq_en | input | 1 | Global interrupt mask (1 lets the request through) |
| irq_req | output | 1 | Masked interrupt request to the CPU |
| pending | output | 1 | Pending latch readback |
| grp_en | output | 1 | Current group enable bit |

## Verification
The checker relies on the options `opt_level` and `opt_port` changing only while reset is asserted. It also relies on `ack` being driven synchronously for single cycles. The bench changes the options only inside its reset task, and it drives every input just after a falling clock edge. Within those limits, the random phases toggle the pin, the port bits, the mask, the acknowledge and the enable writes freely, so coincident acknowledge and edge cases do occur.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
    typedef enum logic [1:0] {
        ST_WARM = 2'd0,
        ST_IDLE = 2'd1,
        ST_PEND = 2'd2
    } latch_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    genvar i;
    for (i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= RST_VAL;
                else        chain[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= RST_VAL;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int PORT_W = 4
) (
    input  logic              line_n,
    input  logic [PORT_W-1:0] port_s,
    input  logic              port_allow,
    output logic              act
);
    logic port_act;

    always_comb begin
        port_act = port_allow & (|port_s);
        act      = ~line_n | port_act;
    end
endmodule

// File: rtl/irq_latch_fsm.sv
module irq_latch_fsm
    import irq_latch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic lvl_mode,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(SYNC_STAGES + 1);
    localparam logic [CW-1:0] WARM_LAST = CW'(SYNC_STAGES);

    latch_state_t  state, nxt;
    logic [CW-1:0] warm_cnt;
    logic          hist;
    logic          edge_hit;

    assign edge_hit = act & ~hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_WARM;
            warm_cnt <= '0;
            hist     <= 1'b1;
        end else begin
            state <= nxt;
            hist  <= act;
            if (state == ST_WARM) warm_cnt <= warm_cnt + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WARM: if (warm_cnt == WARM_LAST)          nxt = ST_IDLE;
            ST_IDLE: if (edge_hit || (lvl_mode && act))  nxt = ST_PEND;
            ST_PEND: if (ack && !edge_hit)               nxt = ST_IDLE;
            default:                                      nxt = ST_WARM;
        endcase
    end

    always_comb begin
        pending = (state == ST_PEND);
    end
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch #(
    parameter int PORT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opt_level,
    input  logic              opt_port,
    input  logic              irq_n,
    input  logic [PORT_W-1:0] port_in,
    input  logic              grp_wr,
    input  logic              grp_wdata,
    input  logic              ack,
    input  logic              irq_en,
    output logic              irq_req,
    output logic              pending,
    output logic              grp_en
);
    logic              line_s_n;
    logic [PORT_W-1:0] port_s;
    logic              merged_act;
    logic              grp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      grp_q <= 1'b0;
        else if (grp_wr) grp_q <= grp_wdata;
    end

    irq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_line (
        .clk(clk), .rst_n(rst_n), .din(irq_n), .dout(line_s_n)
    );

    irq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_port (
        .clk(clk), .rst_n(rst_n), .din(port_in), .dout(port_s)
    );

    irq_merge #(.PORT_W(PORT_W)) u_merge (
        .line_n(line_s_n), .port_s(port_s),
        .port_allow(opt_port & grp_q), .act(merged_act)
    );

    irq_latch_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .act(merged_act),
        .lvl_mode(opt_level), .ack(ack), .pending(pending)
    );

    assign irq_req = pending & irq_en;
    assign grp_en  = grp_q;
endmodule

// File: rtl/ext_irq_latch_chk.sv
module ext_irq_latch_chk (
    input logic clk,
    input logic rst_n,
    input logic opt_level,
    input logic ack,
    input logic irq_en,
    input logic grp_wr,
    input logic irq_req,
    input logic pending,
    input logic grp_en,
    input logic act
);
    assert_mask_blocks_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_req);

    assert_pend_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !ack |=> pending);

    assert_clear_by_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(ack));

    assert_edge_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) && !opt_level |-> $past(act) && !$past(act, 2));

    assert_grp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_wr |=> $stable(grp_en));
endmodule

bind ext_irq_latch ext_irq_latch_chk u_chk (
    .clk(clk), .rst_n(rst_n), .opt_level(opt_level), .ack(ack),
    .irq_en(irq_en), .grp_wr(grp_wr), .irq_req(irq_req),
    .pending(pending), .grp_en(grp_en), .act(merged_act)
);

// File: tb/tb_ext_irq_latch.sv
`timescale 1ns/1ps
module tb_ext_irq_latch;
    localparam int PW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic opt_level = 1'b0, opt_port = 1'b0;
    logic irq_n = 1'b1;
    logic [PW-1:0] port_in = '0;
    logic grp_wr = 1'b0, grp_wdata = 1'b0, ack = 1'b0, irq_en = 1'b1;
    logic irq_req, pending, grp_en;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    ext_irq_latch #(.PORT_W(PW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .opt_level(opt_level), .opt_port(opt_port),
        .irq_n(irq_n), .port_in(port_in), .grp_wr(grp_wr), .grp_wdata(grp_wdata),
        .ack(ack), .irq_en(irq_en), .irq_req(irq_req), .pending(pending),
        .grp_en(grp_en)
    );

    // Reference behaviour taken from the requirements
    logic m_s0, m_s1, m_prev, m_pend, m_grp;
    logic [PW-1:0] m_p0, m_p1;
    int   m_warm;

    function automatic logic ref_act(logic s1, logic [PW-1:0] p1, logic op, logic g);
        return ~s1 | (op & g & (|p1));
    endfunction

    function automatic logic ref_next_pend(logic pend, logic a, logic prv, logic lvl, logic ak);
        logic e;
        e = a & ~prv;
        if (!pend) return e | (lvl & a);
        return !(ak && !e);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s0 <= 1'b1; m_s1 <= 1'b1; m_p0 <= '0; m_p1 <= '0;
            m_prev <= 1'b1; m_pend <= 1'b0; m_grp <= 1'b0; m_warm <= 0;
        end else begin
            m_s0 <= irq_n; m_s1 <= m_s0; m_p0 <= port_in; m_p1 <= m_p0;
            if (grp_wr) m_grp <= grp_wdata;
            m_prev <= ref_act(m_s1, m_p1, opt_port, m_grp);
            if (m_warm < 3) m_warm <= m_warm + 1;
            else m_pend <= ref_next_pend(m_pend, ref_act(m_s1, m_p1, opt_port, m_grp),
                                         m_prev, opt_level, ack);
        end
    end

    task automatic chk(string tag, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_n) begin
                chk(opt_level ? "R5 model" : "R3 model", pending, m_pend);
                chk("R9 model", irq_req, m_pend & irq_en);
                chk("R7 model", grp_en, m_grp);
            end
        end
    endtask

    task automatic do_reset(logic lvl, logic prt);
        rst_n = 1'b0; opt_level = lvl; opt_port = prt;
        ack = 0; grp_wr = 0;
        tick(2);
        chk("R1 pending", pending, 1'b0);
        chk("R1 irq_req", irq_req, 1'b0);
        chk("R1 grp_en", grp_en, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; tick(1); ack = 1'b0;
    endtask

    task automatic write_grp(logic v);
        grp_wr = 1'b1; grp_wdata = v; tick(1); grp_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1a7c));
        // R2: pin already low through reset, edge mode
        irq_n = 1'b0;
        do_reset(1'b0, 1'b0);
        tick(6);
        chk("R2 no false edge", pending, 1'b0);
        // R3: latency of a falling edge
        irq_n = 1'b1; tick(4);
        irq_n = 1'b0; tick(2);
        chk("R3 not yet", pending, 1'b0);
        tick(1);
        chk("R3 latched", pending, 1'b1);
        // R9: mask
        irq_en = 1'b0; tick(1);
        chk("R9 masked req", irq_req, 1'b0);
        chk("R9 pending visible", pending, 1'b1);
        irq_en = 1'b1; tick(1);
        chk("R9 unmasked req", irq_req, 1'b1);
        // R10: holds without ack
        tick(5);
        chk("R10 hold", pending, 1'b1);
        // R4: ack, pin still low
        pulse_ack();
        chk("R6 ack clears", pending, 1'b0);
        tick(5);
        chk("R4 no relatch while low", pending, 1'b0);
        irq_n = 1'b1; tick(4);
        pulse_ack();
        chk("R6 ack idle no effect", pending, 1'b0);
        irq_n = 1'b0; tick(4);
        chk("R4 relatch after release", pending, 1'b1);
        pulse_ack(); irq_n = 1'b1; tick(4);

        // R7: route option off
        do_reset(1'b0, 1'b0);
        tick(4);
        write_grp(1'b1);
        chk("R7 grp write", grp_en, 1'b1);
        port_in = 4'b0100; tick(4);
        chk("R7 route option off", pending, 1'b0);
        port_in = '0;
        // R7: route option on, group disabled then enabled
        do_reset(1'b0, 1'b1);
        tick(4);
        port_in = 4'b0010; tick(4);
        chk("R7 group disabled", pending, 1'b0);
        port_in = '0; tick(3);
        write_grp(1'b1);
        port_in = 4'b0010; tick(4);
        chk("R7 port rising edge", pending, 1'b1);
        // R8: second source while merged active
        pulse_ack();
        irq_n = 1'b0; tick(4);
        chk("R8 no merged edge", pending, 1'b0);
        port_in = '0; irq_n = 1'b1; tick(4);

        // R5: level mode
        do_reset(1'b1, 1'b0);
        tick(6);
        chk("R5 idle", pending, 1'b0);
        irq_n = 1'b0; tick(4);
        chk("R5 level latch", pending, 1'b1);
        pulse_ack();
        chk("R5 one-cycle clear", pending, 1'b0);
        tick(1);
        chk("R5 relatch", pending, 1'b1);
        irq_n = 1'b1; tick(3);
        pulse_ack();
        chk("R5 clear after release", pending, 1'b0);
        tick(3);
        chk("R5 stays clear", pending, 1'b0);

        // Random phases over all option combinations
        for (int cfg = 0; cfg < 4; cfg++) begin
            irq_n = 1'b1; port_in = '0; irq_en = 1'b1;
            do_reset(cfg[0], cfg[1]);
            for (int c = 0; c < 500; c++) begin
                if ($urandom_range(7) == 0) irq_n = ~irq_n;
                for (int b = 0; b < PW; b++)
                    if ($urandom_range(9) == 0) port_in[b] = ~port_in[b];
                ack = ($urandom_range(5) == 0);
                grp_wr = ($urandom_range(19) == 0);
                grp_wdata = $urandom_range(1);
                if ($urandom_range(9) == 0) irq_en = ~irq_en;
                tick(1);
            end
            ack = 1'b0; grp_wr = 1'b0;
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule